// File: doc/BRIEF.md
# Synchronous Detector with Cycle-Aligned Averaging and IIR Smoothing

This block is the digital back end of a lock-in measurement. Signed 16-bit converter samples arrive with a strobe, together with a one-bit reference that marks the phase of the excitation. Each sample is kept as it is while the reference is high and sign-inverted while it is low. For a signal in phase with the reference this gives a full-wave rectified value that runs from zero to the input peak. Noise that is uncorrelated with the reference averages toward zero.

The rectified values are summed over a window that always holds a whole number of reference periods. Period boundaries are the rising edges of the reference. When the window closes, the sum is divided by the number of samples it actually holds, so a period that does not contain an integer number of samples is still averaged correctly. Windows follow each other with no gap.

Each window mean is then smoothed by a single-pole low-pass stage. The stage moves a fraction 2^-k of the way toward the new mean, with k chosen on an input. Because the stage steps once per window, its time constant measured in seconds scales with the excitation period.

Top module: `sync_detect_avg`

## Requirements
- R1: A sample taken with `ref_bit` = 1 enters the sum unchanged. A sample taken with `ref_bit` = 0 enters as its two's-complement negation.
- R2: Negating -32768 gives +32767. The value saturates and does not wrap.
- R3: A clock with `smp_valid` = 0 has no effect. Its data and its `ref_bit` are both ignored, including for edge detection.
- R4: A rising edge is a valid sample with `ref_bit` = 1 whose preceding valid sample had `ref_bit` = 0. After reset the preceding value counts as 0. Valid samples that arrive before the first rising edge after reset are discarded. A window starts with the sample that carries that edge.
- R5: A window closes at the CYCLES-th rising edge after the edge that started it (CYCLES defaults to 20). The edge sample that closes a window is not part of that window; it is the first sample of the next window.
- R6: When a window closes, `avg_data` becomes the window sum divided by the window sample count, truncated toward zero. `avg_valid` is high for exactly one clock, the clock after the closing sample is accepted.
- R7: A window holds at most MAX_SAMPLES samples (default 8191). Valid samples that arrive once the window is full are not added, and the mean uses the first MAX_SAMPLES samples.
- R8: On each `avg_valid`, the filter state y becomes y + ((avg − y) >>> k). The shift is arithmetic, so it rounds toward minus infinity. k is the value of `shift_k` (0 to 15) sampled in that clock. `filt_data` shows y, and `filt_valid` pulses one clock after `avg_valid`. With k = 0 the filter output equals the mean.
- R9: A synchronous reset (`rst` = 1) clears the sum, the counts, the edge history, the filter state, both outputs and both strobes, all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed converter sample |
| ref_bit | input | 1 | Reference phase: 1 passes, 0 inverts |
| shift_k | input | 4 | Filter shift k, sampled when a mean is produced |
| avg_valid | output | 1 | One-clock strobe for a new window mean |
| avg_data | output | 16 | Signed window mean |
| filt_valid | output | 1 | One-clock strobe for a new filter output |
| filt_data | output | 16 | Signed filtered value |

## Verification
The bench runs windows with symmetric reference periods and with asymmetric ones, where the high and low phases carry different values or different lengths. Symmetric periods with antiphase data show whether both polarities are handled. Asymmetric periods show whether the divisor is the real sample count, and a small negative mean shows whether the quotient truncates toward zero. A window that mixes -32768 and +32767 separates saturation from wrapping. A window longer than the sample limit exposes an accumulator that keeps adding. Reset is applied in the middle of a window and then during a leading run of low-reference samples, to show that partial sums and samples before the first edge are dropped. The idle clocks between samples toggle the reference and carry junk data, to show that unstrobed clocks are ignored. Shifts of 0, 1, 2 and 15 check the filter's pass-through and its arithmetic-shift rounding.

// File: rtl/sd_pkg.sv
package sd_pkg;
    localparam int SHIFT_W = 4;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_t;
endpackage

// File: rtl/sd_rectify.sv
module sd_rectify #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     in_pol,
    output logic signed [DATA_W-1:0] out_data
);
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (in_pol) begin
            out_data = in_data;
        end else if (in_data == MIN_V) begin
            out_data = MAX_V;
        end else begin
            out_data = -in_data;
        end
    end
endmodule

// File: rtl/sd_window_avg.sv
module sd_window_avg
    import sd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CYCLES      = 20,
    parameter int MAX_SAMPLES = 8191
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic                     in_ref,
    input  logic signed [DATA_W-1:0] in_rect,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_avg
);
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1);
    localparam int CYC_W = $clog2(CYCLES + 1);
    localparam int ACC_W = DATA_W + CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_SAMPLES);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES - 1);

    typedef struct packed {
        win_state_t               state;
        logic                     ref_prev;
        logic signed [ACC_W-1:0]  sum;
        logic        [CNT_W-1:0]  cnt;
        logic        [CYC_W-1:0]  cyc;
        logic signed [DATA_W-1:0] avg;
        logic                     avg_vld;
    } win_st_t;

    win_st_t st_d, st_q;
    logic                    rise;
    logic signed [ACC_W-1:0] rect_ext;
    logic signed [ACC_W:0]   num_w;
    logic signed [ACC_W:0]   den_w;

    always_comb begin
        rise     = in_ref && !st_q.ref_prev;
        rect_ext = {{(ACC_W-DATA_W){in_rect[DATA_W-1]}}, in_rect};
        num_w    = {st_q.sum[ACC_W-1], st_q.sum};
        den_w    = (st_q.cnt == '0) ? (ACC_W+1)'(1)
                                    : {{(ACC_W+1-CNT_W){1'b0}}, st_q.cnt};

        st_d         = st_q;
        st_d.avg_vld = 1'b0;
        if (in_vld) begin
            st_d.ref_prev = in_ref;
            if (st_q.state == WIN_IDLE) begin
                if (rise) begin
                    st_d.state = WIN_RUN;
                    st_d.sum   = rect_ext;
                    st_d.cnt   = CNT_W'(1);
                    st_d.cyc   = '0;
                end
            end else if (rise && st_q.cyc == CYC_LAST) begin
                st_d.avg     = DATA_W'(num_w / den_w);
                st_d.avg_vld = 1'b1;
                st_d.sum     = rect_ext;
                st_d.cnt     = CNT_W'(1);
                st_d.cyc     = '0;
            end else begin
                if (rise) begin
                    st_d.cyc = st_q.cyc + CYC_W'(1);
                end
                if (st_q.cnt < CNT_MAX) begin
                    st_d.sum = st_q.sum + rect_ext;
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.avg_vld;
    assign out_avg = st_q.avg;

    // R7: the sample count never passes its limit
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_MAX);

    // R5: the edge count inside a window stays below CYCLES
    a_r5_cycle_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cyc <= CYC_LAST);

    // R6: the mean strobe lasts one clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        st_q.avg_vld |=> !st_q.avg_vld);

    // R4: no mean appears while the detector waits for the first edge
    a_r4_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == WIN_IDLE) |-> !st_q.avg_vld);

    // R3: clocks without a sample leave the window untouched
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(st_q.sum) && $stable(st_q.cnt) && $stable(st_q.ref_prev)));
endmodule

// File: rtl/sd_iir_lp.sv
module sd_iir_lp
    import sd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic        [SHIFT_W-1:0] in_k,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_y
);
    typedef struct packed {
        logic signed [DATA_W-1:0] y;
        logic                     vld;
    } iir_st_t;

    iir_st_t st_d, st_q;
    logic signed [DATA_W:0] diff_w;
    logic signed [DATA_W:0] step_w;
    logic signed [DATA_W:0] next_w;

    always_comb begin
        diff_w = {in_x[DATA_W-1], in_x} - {st_q.y[DATA_W-1], st_q.y};
        step_w = diff_w >>> in_k;
        next_w = {st_q.y[DATA_W-1], st_q.y} + step_w;

        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.y = DATA_W'(next_w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_y   = st_q.y;

    // R8: with no shift the filter copies the new mean
    a_r8_passthrough: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_k == '0) |=> (st_q.y == $past(in_x)));

    // R8: the state only moves on an update
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(st_q.y));
endmodule

// File: rtl/sync_detect_avg.sv
module sync_detect_avg
    import sd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CYCLES      = 20,
    parameter int MAX_SAMPLES = 8191
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic signed [DATA_W-1:0]  smp_data,
    input  logic                      ref_bit,
    input  logic        [SHIFT_W-1:0] shift_k,
    output logic                      avg_valid,
    output logic signed [DATA_W-1:0]  avg_data,
    output logic                      filt_valid,
    output logic signed [DATA_W-1:0]  filt_data
);
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] rect;

    sd_rectify #(.DATA_W(DATA_W)) u_rect (
        .in_data  (smp_data),
        .in_pol   (ref_bit),
        .out_data (rect)
    );

    sd_window_avg #(
        .DATA_W      (DATA_W),
        .CYCLES      (CYCLES),
        .MAX_SAMPLES (MAX_SAMPLES)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (smp_valid),
        .in_ref  (ref_bit),
        .in_rect (rect),
        .out_vld (avg_valid),
        .out_avg (avg_data)
    );

    sd_iir_lp #(.DATA_W(DATA_W)) u_iir (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (avg_valid),
        .in_x    (avg_data),
        .in_k    (shift_k),
        .out_vld (filt_valid),
        .out_y   (filt_data)
    );

    // R2: an inverted sample never comes out as the most negative code
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !ref_bit) |-> (rect != MIN_V));

    // R1: with the reference high the sample passes unchanged
    a_r1_pass: assert property (@(posedge clk) disable iff (rst)
        ref_bit |-> (rect == smp_data));

    // R8: the filter strobe trails the mean strobe by one clock
    a_r8_follow: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> filt_valid);
endmodule

// File: tb/tb_sync_detect_avg.sv
`timescale 1ns/1ps
module tb_sync_detect_avg;
    localparam int N   = 4;
    localparam int MAX = 64;
    localparam int NV  = 8;
    // each row: high value, low value, high length, low length, shift
    localparam int VEC [NV][5] = '{
        '{  1000,  -1000,  3,  3,  0 },
        '{   500,   -500,  2,  5,  1 },
        '{ 32767, -32768,  4,  4,  2 },
        '{  1200,    300,  3,  4,  0 },
        '{    -7,      0,  1,  2,  0 },
        '{     0,      0,  2,  2, 15 },
        '{  -900,    900,  1,  1,  1 },
        '{   100,     50, 40, 40,  0 }
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic ref_bit = 1'b0;
    logic [3:0] shift_k = '0;
    logic avg_valid, filt_valid;
    logic signed [15:0] avg_data, filt_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_armed, m_prev;
    longint m_sum;
    int m_cnt, m_cyc, m_y, exp_avg;

    always #2.5 clk = ~clk;

    sync_detect_avg #(.DATA_W(16), .CYCLES(N), .MAX_SAMPLES(MAX)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .ref_bit(ref_bit), .shift_k(shift_k), .avg_valid(avg_valid),
        .avg_data(avg_data), .filt_valid(filt_valid), .filt_data(filt_data)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int rectify(input int v, input bit r);
        if (r) return v;
        if (v == -32768) return 32767;
        return -v;
    endfunction

    task automatic model_reset();
        m_armed = 0; m_prev = 0; m_sum = 0; m_cnt = 0; m_cyc = 0; m_y = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one valid clock followed by one idle clock carrying junk (R3)
    task automatic drive_sample(input int v, input bit r, input string tag);
        int  rv;
        bit  rise, closing;
        rv = rectify(v, r);
        rise = r && !m_prev;
        m_prev = r;
        closing = 0;
        if (!m_armed) begin
            if (rise) begin m_armed = 1; m_sum = rv; m_cnt = 1; m_cyc = 0; end
        end else if (rise && m_cyc == N-1) begin
            closing = 1;
            exp_avg = int'(m_sum / longint'(m_cnt));
            m_y = m_y + ((exp_avg - m_y) >>> int'(shift_k));
            m_sum = rv; m_cnt = 1; m_cyc = 0;
        end else begin
            if (rise) m_cyc++;
            if (m_cnt < MAX) begin m_sum += rv; m_cnt++; end
        end
        smp_data = 16'(v); ref_bit = r; smp_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        check({tag, " R6 avg_valid"}, int'(avg_valid), int'(closing));
        if (closing) check({tag, " R1 R2 R5 R6 R7 avg_data"}, int'(avg_data), exp_avg);
        smp_valid = 1'b0; smp_data = 16'd12345; ref_bit = ~r;
        @(posedge clk); @(negedge clk);
        check({tag, " R6 pulse width"}, int'(avg_valid), 0);
        check({tag, " R8 filt_valid"}, int'(filt_valid), int'(closing));
        if (closing) check({tag, " R8 filt_data"}, int'(filt_data), m_y);
    endtask

    task automatic run_cycles(input int a, input int b, input int hi, input int lo,
                              input int ncyc, input string tag);
        for (int c = 0; c < ncyc; c++) begin
            for (int h = 0; h < hi; h++) drive_sample(a, 1'b1, tag);
            for (int l = 0; l < lo; l++) drive_sample(b, 1'b0, tag);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 avg_valid reset", int'(avg_valid), 0);
        check("R9 filt_valid reset", int'(filt_valid), 0);
        check("R9 avg_data reset", int'(avg_data), 0);
        check("R9 filt_data reset", int'(filt_data), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            shift_k = 4'(VEC[i][4]);
            run_cycles(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], N, "vec");
        end
        drive_sample(0, 1'b1, "vec close");

        // R9: reset in the middle of a window drops the partial sum and filter state
        shift_k = 4'd1;
        run_cycles(5000, -5000, 2, 2, 2, "pre-reset");
        do_reset();
        check("R9 avg_valid after mid reset", int'(avg_valid), 0);
        check("R9 filt_data after mid reset", int'(filt_data), 0);
        run_cycles(200, -200, 2, 2, N, "R9 fresh");
        drive_sample(0, 1'b1, "R9 fresh close");
        check("R9 mean after reset", exp_avg, 200);
        check("R8 first filter step from zero", int'(filt_data), 100);

        // R4: samples before the first rising edge are discarded
        do_reset();
        shift_k = 4'd0;
        for (int j = 0; j < 5; j++) drive_sample(9000, 1'b0, "R4 lead");
        run_cycles(100, -100, 3, 2, N, "R4 window");
        drive_sample(0, 1'b1, "R4 close");
        check("R4 leading samples ignored", int'(avg_data), 100);

        // R7: a window longer than the limit averages the first samples only
        do_reset();
        run_cycles(100, 50, 40, 40, N, "R7 window");
        drive_sample(0, 1'b1, "R7 close");
        check("R7 limited mean", int'(avg_data), 43);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule